// File: doc/BRIEF.md
# Exception Stack Frame Engine

This block carries out the stack work a processor core does when it takes an exception and when it returns from one. The core raises `entry_req` with the exception number, its status word, the return PC, an optional fault address and a hardware-interrupt flag. The engine then computes the new status word and picks the supervisor stack. It writes a typed frame onto that stack through a single 16/32-bit memory port, and finally reads the handler address from the vector table. A hardware interrupt whose level does not beat the current mask is refused without any memory traffic.

On `rte_req` the engine pops a frame from the active supervisor stack. It restores the status word and the PC and steps past any extra words that belong to the frame's format code. A format-1 frame is a throwaway: the engine applies its status word, moves to the stack that status word selects, and pops again. Each sequence runs under a `busy` flag, makes at most one memory access per cycle, and ends with a single-cycle `done`, when the results on the output ports are valid.

Top module: `exc_frame_engine`

## Requirements
- R1: A request with `is_hw`=1 is accepted only when `sr_in[10:8]` is numerically below `pend_lvl`. A refused request ends with `rejected`=1 and makes no memory access. `sr_out`, `pc_out`, `isp_out` and `msp_out` then equal `sr_in`, `pc_in`, `isp_in` and `msp_in`.
- R2: On an accepted entry the status word becomes `sr_in` with bit 13 (supervisor) set and bit 15 (trace) cleared. For a hardware interrupt, bits 10:8 are also loaded with `pend_lvl`. The frame holds the unmodified `sr_in`.
- R3: With `ALIGN_SP`=1, bit 0 of the chosen stack pointer is cleared before the first write. The chosen pointer is `msp_in` when bit 12 (master) of the new status word is set, and `isp_in` otherwise.
- R4: The frame is written downward in this order: first the format-specific longwords, then the 16-bit word `(format<<12)|(exc_num*4)`, then the 32-bit return PC, and last the 16-bit old status word at the lowest address. The stack pointer is decremented before each write.
- R5: Exception numbers 3, 5, 6, 7 and 9 use format 2, whose one extra longword is `fault_addr`. Every other number uses format 0, with no extra longwords.
- R6: A hardware interrupt taken while `sr_in` bit 12 is set first writes a format-0 frame on the master stack. It then clears bit 12, moves to the aligned interrupt stack, and writes a format-1 frame that carries the updated status word (bit 12 still set). The final `sr_out` has bit 12 clear.
- R7: After the frame, one 32-bit read at `vbr + exc_num*4` supplies `pc_out`. The final stack pointer is written back to the stack in use, and the other stack keeps its input value.
- R8: A return reads the status word (16 bits) at the stack pointer, then the PC (32 bits) at +2, then the format word (16 bits) at +6. The stack is chosen by `sr_in` bit 12. `sr_out` and `pc_out` take the popped values, and the advanced pointer is written back to the stack it was popped from.
- R9: After the format word, a return advances the pointer by 4 more bytes for formats 2 and 3, by 8 for format 4, by 52 for format 7, and by nothing for any other format.
- R10: A popped format of 1 causes the pointer to be written back and the popped status word to be applied. The pop sequence then restarts on the stack that the popped word's bit 12 selects.
- R11: After reset, `busy`, `done` and `mem_req` are 0. `busy` is high from the cycle after a request until `done`, and `done` lasts exactly one cycle. `mem_req` is never high outside `busy`, and `mem_long` gives the access size (1 = 32 bits, 0 = 16 bits in `mem_wdata[15:0]`/`mem_rdata[15:0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Start an exception entry (sampled while idle) |
| rte_req | input | 1 | Start a return from exception (sampled while idle) |
| is_hw | input | 1 | Entry is a hardware interrupt |
| pend_lvl | input | 3 | Pending hardware interrupt level |
| exc_num | input | NUM_W | Exception number |
| sr_in | input | 16 | Current status word |
| pc_in | input | AW | Return PC for entry |
| fault_addr | input | AW | Address stored in a format-2 frame |
| vbr | input | AW | Vector table base |
| isp_in | input | AW | Interrupt stack pointer |
| msp_in | input | AW | Master stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| rejected | output | 1 | Last entry was a refused interrupt |
| sr_out | output | 16 | Resulting status word |
| pc_out | output | AW | Handler address or restored PC |
| isp_out | output | AW | Resulting interrupt stack pointer |
| msp_out | output | AW | Resulting master stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = 32-bit, 0 = 16-bit |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data, valid in the cycle of the read |

## Verification
The hardest case to reach from the ports is the return path through a throwaway frame. It needs a format-1 frame above a format-0 frame, on two different stacks, with matching status words. The bench gets there by first taking a hardware interrupt with the master bit set, which makes the engine build the two-frame pair itself. It then issues a return with the resulting status word and pointers, so both stack switches and the final status are checked against frames built by the design's own writes. Return formats 3, 4, 7 and an unknown code are covered with frames the bench writes directly into its memory model.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int SR_W    = 16;
  localparam int SR_TRC  = 15;
  localparam int SR_SUP  = 13;
  localparam int SR_MST  = 12;
  localparam int SR_IMH  = 10;
  localparam int SR_IML  = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_XTRA,
    ST_FV,
    ST_PC,
    ST_SR,
    ST_VEC,
    ST_RSR,
    ST_RPC,
    ST_RFV,
    ST_DONE
  } st_t;

  // frame format chosen by exception class
  function automatic logic [3:0] frame_fmt(input int unsigned n);
    case (n)
      3, 5, 6, 7, 9: frame_fmt = 4'd2;
      default:       frame_fmt = 4'd0;
    endcase
  endfunction

  // bytes beyond the format word that a return must step over
  function automatic logic [5:0] skip_bytes(input logic [3:0] f);
    case (f)
      4'd2, 4'd3: skip_bytes = 6'd4;
      4'd4:       skip_bytes = 6'd8;
      4'd7:       skip_bytes = 6'd52;
      default:    skip_bytes = 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/exc_sr_unit.sv
module exc_sr_unit
  import exc_pkg::*;
#(
  parameter int NUM_W = 8
) (
  input  logic [SR_W-1:0]  sr_in,
  input  logic             is_hw,
  input  logic [2:0]       pend_lvl,
  input  logic [NUM_W-1:0] exc_num,
  output logic             accept,
  output logic [SR_W-1:0]  sr_entry,
  output logic [3:0]       fmt
);

  logic [2:0] cur_mask;

  assign cur_mask = sr_in[SR_IMH:SR_IML];
  assign accept   = !is_hw || (cur_mask < pend_lvl);
  assign fmt      = frame_fmt(32'(exc_num));

  always_comb begin
    sr_entry         = sr_in;
    sr_entry[SR_SUP] = 1'b1;
    sr_entry[SR_TRC] = 1'b0;
    if (is_hw) sr_entry[SR_IMH:SR_IML] = pend_lvl;
  end

endmodule

// File: rtl/exc_bus_drv.sv
module exc_bus_drv
  import exc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NUM_W = 8
) (
  input  st_t              st,
  input  logic [AW-1:0]    sp,
  input  logic [AW-1:0]    fa,
  input  logic [AW-1:0]    pc_ret,
  input  logic [AW-1:0]    vbr,
  input  logic [SR_W-1:0]  frame_sr,
  input  logic [3:0]       fmt,
  input  logic [NUM_W-1:0] num,
  output logic             req,
  output logic             we,
  output logic             lng,
  output logic [AW-1:0]    addr,
  output logic [AW-1:0]    wdata
);

  localparam int VOFF_W = NUM_W + 2;

  logic [VOFF_W-1:0] voff;
  logic [SR_W-1:0]   fv_word;

  assign voff    = {num, 2'b00};
  assign fv_word = {fmt, 12'(voff)};

  always_comb begin
    req   = 1'b0;
    we    = 1'b0;
    lng   = 1'b0;
    addr  = '0;
    wdata = '0;
    case (st)
      ST_XTRA: begin req = 1'b1; we = 1'b1; lng = 1'b1; addr = sp - AW'(4); wdata = fa; end
      ST_FV:   begin req = 1'b1; we = 1'b1; addr = sp - AW'(2); wdata = AW'(fv_word); end
      ST_PC:   begin req = 1'b1; we = 1'b1; lng = 1'b1; addr = sp - AW'(4); wdata = pc_ret; end
      ST_SR:   begin req = 1'b1; we = 1'b1; addr = sp - AW'(2); wdata = AW'(frame_sr); end
      ST_VEC:  begin req = 1'b1; lng = 1'b1; addr = vbr + AW'(voff); end
      ST_RSR:  begin req = 1'b1; addr = sp; end
      ST_RPC:  begin req = 1'b1; lng = 1'b1; addr = sp; end
      ST_RFV:  begin req = 1'b1; addr = sp; end
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_frame_engine.sv
module exc_frame_engine
  import exc_pkg::*;
#(
  parameter int AW       = 32,
  parameter int NUM_W    = 8,
  parameter bit ALIGN_SP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_req,
  input  logic             rte_req,
  input  logic             is_hw,
  input  logic [2:0]       pend_lvl,
  input  logic [NUM_W-1:0] exc_num,
  input  logic [15:0]      sr_in,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    fault_addr,
  input  logic [AW-1:0]    vbr,
  input  logic [AW-1:0]    isp_in,
  input  logic [AW-1:0]    msp_in,
  output logic             busy,
  output logic             done,
  output logic             rejected,
  output logic [15:0]      sr_out,
  output logic [AW-1:0]    pc_out,
  output logic [AW-1:0]    isp_out,
  output logic [AW-1:0]    msp_out,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_long,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    mem_wdata,
  input  logic [AW-1:0]    mem_rdata
);

  function automatic logic [AW-1:0] fix_sp(input logic [AW-1:0] a);
    fix_sp = ALIGN_SP ? {a[AW-1:1], 1'b0} : a;
  endfunction

  st_t              st;
  logic [AW-1:0]    sp, isp_r, msp_r, pc_r, pc_ret, fa_r, vbr_r;
  logic [SR_W-1:0]  sr_r, frame_sr, fsr_tmp;
  logic [3:0]       fmt_r;
  logic [NUM_W-1:0] num_r;
  logic             dbl_r, entry_r, rej_r;

  logic             accept;
  logic [SR_W-1:0]  sr_entry;
  logic [3:0]       fmt_new;

  // named events for the checker
  logic             ev_vec, ev_throwaway;
  logic [3:0]       pop_fmt;
  logic [AW-1:0]    pop_sp, push_sp;

  assign pop_fmt      = mem_rdata[15:12];
  assign pop_sp       = sp + AW'(2) + AW'(skip_bytes(pop_fmt));
  assign push_sp      = sp - AW'(2);
  assign ev_vec       = (st == ST_VEC);
  assign ev_throwaway = (st == ST_RFV) && (pop_fmt == 4'd1);

  exc_sr_unit #(.NUM_W(NUM_W)) u_sr (
    .sr_in    (sr_in),
    .is_hw    (is_hw),
    .pend_lvl (pend_lvl),
    .exc_num  (exc_num),
    .accept   (accept),
    .sr_entry (sr_entry),
    .fmt      (fmt_new)
  );

  exc_bus_drv #(.AW(AW), .NUM_W(NUM_W)) u_bus (
    .st       (st),
    .sp       (sp),
    .fa       (fa_r),
    .pc_ret   (pc_ret),
    .vbr      (vbr_r),
    .frame_sr (frame_sr),
    .fmt      (fmt_r),
    .num      (num_r),
    .req      (mem_req),
    .we       (mem_we),
    .lng      (mem_long),
    .addr     (mem_addr),
    .wdata    (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sp       <= '0;
      isp_r    <= '0;
      msp_r    <= '0;
      pc_r     <= '0;
      pc_ret   <= '0;
      fa_r     <= '0;
      vbr_r    <= '0;
      sr_r     <= '0;
      frame_sr <= '0;
      fsr_tmp  <= '0;
      fmt_r    <= '0;
      num_r    <= '0;
      dbl_r    <= 1'b0;
      entry_r  <= 1'b0;
      rej_r    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (entry_req) begin
            num_r   <= exc_num;
            fa_r    <= fault_addr;
            pc_ret  <= pc_in;
            vbr_r   <= vbr;
            isp_r   <= isp_in;
            msp_r   <= msp_in;
            entry_r <= 1'b1;
            if (!accept) begin
              rej_r <= 1'b1;
              sr_r  <= sr_in;
              pc_r  <= pc_in;
              st    <= ST_DONE;
            end else begin
              rej_r    <= 1'b0;
              sr_r     <= sr_entry;
              frame_sr <= sr_in;
              fmt_r    <= fmt_new;
              dbl_r    <= is_hw && sr_in[SR_MST];
              sp       <= fix_sp(sr_entry[SR_MST] ? msp_in : isp_in);
              st       <= (fmt_new == 4'd2) ? ST_XTRA : ST_FV;
            end
          end else if (rte_req) begin
            entry_r <= 1'b0;
            rej_r   <= 1'b0;
            sr_r    <= sr_in;
            isp_r   <= isp_in;
            msp_r   <= msp_in;
            sp      <= sr_in[SR_MST] ? msp_in : isp_in;
            st      <= ST_RSR;
          end
        end
        ST_XTRA: begin sp <= sp - AW'(4); st <= ST_FV; end
        ST_FV:   begin sp <= push_sp;     st <= ST_PC; end
        ST_PC:   begin sp <= sp - AW'(4); st <= ST_SR; end
        ST_SR: begin
          if (sr_r[SR_MST]) msp_r <= push_sp;
          else              isp_r <= push_sp;
          if (dbl_r) begin
            dbl_r        <= 1'b0;
            frame_sr     <= sr_r;
            sr_r[SR_MST] <= 1'b0;
            fmt_r        <= 4'd1;
            sp           <= fix_sp(isp_r);
            st           <= ST_FV;
          end else begin
            sp <= push_sp;
            st <= ST_VEC;
          end
        end
        ST_VEC: begin pc_r <= mem_rdata; st <= ST_DONE; end
        ST_RSR: begin fsr_tmp <= mem_rdata[SR_W-1:0]; sp <= sp + AW'(2); st <= ST_RPC; end
        ST_RPC: begin pc_r <= mem_rdata; sp <= sp + AW'(4); st <= ST_RFV; end
        ST_RFV: begin
          if (sr_r[SR_MST]) msp_r <= pop_sp;
          else              isp_r <= pop_sp;
          sr_r <= fsr_tmp;
          if (ev_throwaway) begin
            if (fsr_tmp[SR_MST]) sp <= sr_r[SR_MST] ? pop_sp : msp_r;
            else                 sp <= sr_r[SR_MST] ? isp_r : pop_sp;
            st <= ST_RSR;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_DONE);
  assign rejected = rej_r;
  assign sr_out   = sr_r;
  assign pc_out   = pc_r;
  assign isp_out  = isp_r;
  assign msp_out  = msp_r;

endmodule

// File: rtl/exc_frame_engine_chk.sv
module exc_frame_engine_chk #(
  parameter int AW       = 32,
  parameter bit ALIGN_SP = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          rejected,
  input logic          entry_r,
  input logic [15:0]   sr_out,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_long,
  input logic [AW-1:0] mem_addr,
  input logic          ev_vec
);

  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R11

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_PUSH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ALIGN_SP && mem_req && mem_we) |-> !mem_addr[0]); // R3

  AST_ENTRY_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && entry_r && !rejected) |-> (sr_out[13] && !sr_out[15])); // R2

  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rejected) |-> !$past(mem_req)); // R1

  AST_VECTOR_LONG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec |-> (mem_req && !mem_we && mem_long)); // R7

endmodule

bind exc_frame_engine exc_frame_engine_chk #(.AW(AW), .ALIGN_SP(ALIGN_SP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .rejected (rejected),
  .entry_r  (entry_r),
  .sr_out   (sr_out),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_long (mem_long),
  .mem_addr (mem_addr),
  .ev_vec   (ev_vec)
);

// File: tb/test_exc_frame_engine.sv
`timescale 1ns/1ps
module test_exc_frame_engine;

  localparam int AW = 32;
  localparam bit [31:0] VBR = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic entry_req = 1'b0, rte_req = 1'b0, is_hw = 1'b0;
  logic [2:0]  pend_lvl = '0;
  logic [7:0]  exc_num = '0;
  logic [15:0] sr_in = '0;
  logic [31:0] pc_in = '0, fault_addr = '0, vbr = VBR, isp_in = '0, msp_in = '0;
  logic busy, done, rejected, mem_req, mem_we, mem_long;
  logic [15:0] sr_out;
  logic [31:0] pc_out, isp_out, msp_out, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  exc_frame_engine i_exc_frame_engine (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .rte_req(rte_req),
    .is_hw(is_hw), .pend_lvl(pend_lvl), .exc_num(exc_num), .sr_in(sr_in),
    .pc_in(pc_in), .fault_addr(fault_addr), .vbr(vbr), .isp_in(isp_in),
    .msp_in(msp_in), .busy(busy), .done(done), .rejected(rejected),
    .sr_out(sr_out), .pc_out(pc_out), .isp_out(isp_out), .msp_out(msp_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_tag = "R11";

  typedef struct { bit we; bit lng; bit [31:0] addr; bit [31:0] data; } op_t;
  op_t expq[$];

  bit [7:0]  mem [bit [31:0]];
  bit [31:0] m_sp;
  bit        e_rej;
  bit [15:0] e_sr;
  bit [31:0] e_pc, e_isp, e_msp;

  function automatic bit [7:0] rd8(bit [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic bit [15:0] rd16(bit [31:0] a);
    return {rd8(a), rd8(a + 1)};
  endfunction
  function automatic bit [31:0] rd32(bit [31:0] a);
    return {rd16(a), rd16(a + 2)};
  endfunction
  task automatic wr16(bit [31:0] a, bit [15:0] v);
    mem[a] = v[15:8]; mem[a + 1] = v[7:0];
  endtask
  task automatic wr32(bit [31:0] a, bit [31:0] v);
    wr16(a, v[31:16]); wr16(a + 2, v[15:0]);
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // bus monitor and memory model
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (expq.size() == 0) begin
        chk("R11", "unexpected bus access addr", mem_addr, 32'hFFFF_FFFF);
      end else begin
        op_t e;
        e = expq.pop_front();
        chk(cur_tag, "bus direction", {31'b0, mem_we}, {31'b0, e.we});
        chk(cur_tag, "bus size", {31'b0, mem_long}, {31'b0, e.lng});
        chk(cur_tag, "bus address", mem_addr, e.addr);
        if (e.we) begin
          chk(cur_tag, "bus write data", e.lng ? mem_wdata : {16'b0, mem_wdata[15:0]}, e.data);
          if (e.lng) wr32(mem_addr, mem_wdata); else wr16(mem_addr, mem_wdata[15:0]);
        end else begin
          mem_rdata = mem_long ? rd32(mem_addr) : {16'b0, rd16(mem_addr)};
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R11 watchdog expired: actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic push_op(bit lng, bit [31:0] v);
    m_sp = m_sp - (lng ? 32'd4 : 32'd2);
    expq.push_back('{we: 1'b1, lng: lng, addr: m_sp, data: lng ? v : {16'b0, v[15:0]}});
  endtask

  task automatic model_entry(bit [7:0] num, bit hw, bit [2:0] lvl, bit [15:0] sr,
                             bit [31:0] pc, bit [31:0] fa, bit [31:0] isp, bit [31:0] msp);
    bit [15:0] nsr;
    bit [15:0] fvw;
    bit two;
    expq.delete();
    e_isp = isp; e_msp = msp; e_rej = 1'b0;
    if (hw && !(sr[10:8] < lvl)) begin
      e_rej = 1'b1; e_sr = sr; e_pc = pc;
      return;
    end
    nsr = (sr | 16'h2000) & 16'h7FFF;
    if (hw) nsr[10:8] = lvl;
    two = (num == 3) || (num == 5) || (num == 6) || (num == 7) || (num == 9);
    m_sp = nsr[12] ? msp : isp;
    m_sp[0] = 1'b0;
    fvw = (two ? 16'h2000 : 16'h0000) | (16'(num) * 16'd4);
    if (two) push_op(1'b1, fa);
    push_op(1'b0, {16'b0, fvw});
    push_op(1'b1, pc);
    push_op(1'b0, {16'b0, sr});
    if (hw && sr[12]) begin
      e_msp = m_sp;
      e_sr = nsr & 16'hEFFF;
      m_sp = isp & 32'hFFFF_FFFE;
      push_op(1'b0, {16'b0, 16'h1000 | (16'(num) * 16'd4)});
      push_op(1'b1, pc);
      push_op(1'b0, {16'b0, nsr});
      e_isp = m_sp;
    end else begin
      e_sr = nsr;
      if (nsr[12]) e_msp = m_sp; else e_isp = m_sp;
    end
    expq.push_back('{we: 1'b0, lng: 1'b1, addr: VBR + 32'(num) * 4, data: 32'h0});
    e_pc = rd32(VBR + 32'(num) * 4);
  endtask

  task automatic model_rte(bit [15:0] sr, bit [31:0] isp, bit [31:0] msp);
    bit [15:0] cur, s, fv;
    bit [31:0] p;
    int extra;
    expq.delete();
    cur = sr; e_isp = isp; e_msp = msp; e_rej = 1'b0;
    m_sp = cur[12] ? msp : isp;
    for (int k = 0; k < 4; k++) begin
      s = rd16(m_sp);
      expq.push_back('{we: 1'b0, lng: 1'b0, addr: m_sp, data: 32'h0});
      p = rd32(m_sp + 2);
      expq.push_back('{we: 1'b0, lng: 1'b1, addr: m_sp + 2, data: 32'h0});
      fv = rd16(m_sp + 6);
      expq.push_back('{we: 1'b0, lng: 1'b0, addr: m_sp + 6, data: 32'h0});
      case (fv[15:12])
        4'd2, 4'd3: extra = 4;
        4'd4:       extra = 8;
        4'd7:       extra = 52;
        default:    extra = 0;
      endcase
      m_sp = m_sp + 8 + 32'(extra);
      if (cur[12]) e_msp = m_sp; else e_isp = m_sp;
      cur = s;
      if (fv[15:12] != 4'd1) break;
      m_sp = cur[12] ? e_msp : e_isp;
    end
    e_sr = cur; e_pc = p;
  endtask

  task automatic wait_done(string tag);
    int n;
    n = 0;
    chk("R11", "busy after request", {31'b0, busy}, 32'd1);
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk("R11", "done strobe", {31'b0, done}, 32'd1);
    chk(tag, "pending bus accesses", expq.size(), 32'd0);
    chk(tag, "rejected", {31'b0, rejected}, {31'b0, e_rej});
    chk(tag, "sr_out", {16'b0, sr_out}, {16'b0, e_sr});
    chk(tag, "pc_out", pc_out, e_pc);
    chk(tag, "isp_out", isp_out, e_isp);
    chk(tag, "msp_out", msp_out, e_msp);
    @(negedge clk);
    chk("R11", "done single cycle", {31'b0, done}, 32'd0);
    chk("R11", "idle after done", {31'b0, busy}, 32'd0);
  endtask

  task automatic do_entry(string tag, bit [7:0] num, bit hw, bit [2:0] lvl, bit [15:0] sr,
                          bit [31:0] pc, bit [31:0] fa, bit [31:0] isp, bit [31:0] msp);
    model_entry(num, hw, lvl, sr, pc, fa, isp, msp);
    cur_tag = tag;
    exc_num = num; is_hw = hw; pend_lvl = lvl; sr_in = sr; pc_in = pc;
    fault_addr = fa; isp_in = isp; msp_in = msp;
    entry_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0;
    wait_done(tag);
  endtask

  task automatic do_rte(string tag, bit [15:0] sr, bit [31:0] isp, bit [31:0] msp);
    model_rte(sr, isp, msp);
    cur_tag = tag;
    sr_in = sr; isp_in = isp; msp_in = msp;
    rte_req = 1'b1;
    @(negedge clk);
    rte_req = 1'b0;
    wait_done(tag);
  endtask

  initial begin
    bit [15:0] s1;
    bit [31:0] i1, m1;
    for (int i = 0; i < 64; i++) wr32(VBR + 32'(i) * 4, 32'hA000_0000 + 32'(i) * 16);
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", {31'b0, busy}, 32'd0);
    chk("R11", "reset done", {31'b0, done}, 32'd0);
    chk("R11", "reset mem_req", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 odd interrupt stack, trace set, user mode, illegal instruction
    do_entry("R3", 8'd4, 1'b0, 3'd0, 16'h8004, 32'h0000_0100, 32'h0, 32'h0000_8001, 32'h0000_C000);
    s1 = e_sr; i1 = e_isp; m1 = e_msp;
    // R4 trap with format 0 on an even stack
    do_entry("R4", 8'd32, 1'b0, 3'd0, 16'h2000, 32'h0000_0200, 32'h0, 32'h0000_8800, 32'h0000_C000);
    // R5 divide by zero, trace and CHK carry the fault address
    do_entry("R5", 8'd5, 1'b0, 3'd0, 16'h2004, 32'h0000_0300, 32'h0000_0222, 32'h0000_9000, 32'h0000_C000);
    do_entry("R5", 8'd9, 1'b0, 3'd0, 16'h0000, 32'h0000_0310, 32'h0000_0333, 32'h0000_9100, 32'h0000_C000);
    do_entry("R5", 8'd6, 1'b0, 3'd0, 16'h3000, 32'h0000_0320, 32'h0000_0444, 32'h0000_9200, 32'h0000_C400);
    // R7 TRAPcc vector fetch
    do_entry("R7", 8'd7, 1'b0, 3'd0, 16'h2010, 32'h0000_0330, 32'h0000_0555, 32'h0000_9300, 32'h0000_C000);
    // R2 hardware interrupt loads the mask
    do_entry("R2", 8'd26, 1'b1, 3'd5, 16'hA200, 32'h0000_0400, 32'h0, 32'h0000_9400, 32'h0000_C000);
    // R1 refused and accepted interrupts
    do_entry("R1", 8'd27, 1'b1, 3'd3, 16'h2300, 32'h0000_0500, 32'h0, 32'h0000_9500, 32'h0000_C000);
    do_entry("R1", 8'd31, 1'b1, 3'd7, 16'h2600, 32'h0000_0510, 32'h0, 32'h0000_9600, 32'h0000_C000);
    // R6 interrupt with the master bit set builds two frames
    do_entry("R6", 8'd28, 1'b1, 3'd4, 16'h3100, 32'h0000_4444, 32'h0, 32'h0000_9801, 32'h0000_C801);
    // R10 return through the throwaway frame
    do_rte("R10", e_sr, e_isp, e_msp);
    // R8 return of the first frame
    do_rte("R8", s1, i1, m1);
    // R9 return skips per format
    for (int k = 0; k < 5; k++) begin
      bit [31:0] b;
      bit [3:0] f;
      b = 32'h0000_A000 + 32'(k) * 32'h100;
      f = (k == 0) ? 4'd2 : (k == 1) ? 4'd3 : (k == 2) ? 4'd4 : (k == 3) ? 4'd7 : 4'd15;
      wr16(b, 16'h0011 + 16'(k));
      wr32(b + 2, 32'h0000_5000 + 32'(k));
      wr16(b + 6, {f, 12'h018});
      do_rte("R9", 16'h2000, b, 32'h0000_C000);
    end
    // R8 return from the master stack
    wr16(32'h0000_B000, 16'h0704);
    wr32(32'h0000_B002, 32'h0000_6060);
    wr16(32'h0000_B006, 16'h0010);
    do_rte("R8", 16'h3000, 32'h0000_8000, 32'h0000_B000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule